// File: doc/BRIEF.md
# Double-Sampled Self-Correcting Pipeline Register

This block is one register stage of a feed-forward pipeline that is run at a clock faster than its worst-case path allows. It samples its data input twice. The main register takes the input on the rising edge of the main clock. A shadow register takes the same input a fraction of a cycle later, on the rising edge of a phase-delayed copy of that clock. If the input was still settling at the main edge, the two samples disagree. The late sample is then taken as the correct one.

On the next main edge the stage compares the two samples. When they differ, it overwrites its own output with the shadow value, raises a registered stall for exactly one cycle, and counts the event in a saturating counter. While the stall is high, the upstream stage must hold its data and the downstream stage must discard what it took on the previous edge. When the two samples match, the data flows through with no stall. The comparison is switched off for the one cycle after a correction, because in that cycle the shadow already holds data for the next slot. Generating the delayed clock and handling the stall in the pipeline are left to the surrounding logic.

Top module: `timing_shadow_reg`

## Requirements
- R1: While reset is low and immediately after it is released, `dOut` is 0, `stall` is 0 and `errCount` is 0. A later reset clears `errCount` back to 0.
- R2: When `dIn` is stable across both the main edge and the delayed edge, `dOut` shows that value after the main edge that captured it.
- R3: If the value in the main register differs from the shadow value at a main edge where checking is enabled, that edge loads the shadow value into `dOut` and sets `stall` to 1.
- R4: `stall` stays high for exactly one main-clock cycle. At the main edge that ends the stall, the stage captures `dIn` again.
- R5: A stream of values that change only after the delayed edge produces no stall and leaves `errCount` unchanged.
- R6: At the main edge that ends a stall, no comparison is made. A shadow sample taken during the stall cycle that differs from the corrected output causes no stall.
- R7: `errCount` rises by exactly one for each correction and changes at no other time.
- R8: `errCount` saturates at 2^CNT_W-1. Corrections made after that still update `dOut` and pulse `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMain | input | 1 | Main pipeline clock |
| clkLate | input | 1 | Phase-delayed copy of clkMain used by the shadow sample |
| rstN | input | 1 | Asynchronous active-low reset |
| dIn | input | DATA_W | Data from the upstream stage |
| dOut | output | DATA_W | Registered stage output |
| stall | output | 1 | One-cycle stall request to the pipeline after a correction |
| errCount | output | CNT_W | Saturating count of corrections |

## Verification
The hardest case to reach from the ports is a real disagreement between the two samples. It only happens when `dIn` changes inside the narrow window between the main edge and the delayed edge. The bench creates this by moving `dIn` one nanosecond after a main edge, which is before the delayed clock, two nanoseconds behind, samples it. The case where checking is suppressed needs a second change of this kind, placed inside the stall cycle itself. Saturation needs the counter width reduced at the bench so that it can be reached with a modest number of injected errors.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // Strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic takeShadow;  // load the late sample into the main register
    logic raiseStall;  // a correction happens on this edge
  } tsrStrobes_t;
endpackage

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clkMain,
  input  logic              clkLate,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  tsrStrobes_t       strb,
  output logic [DATA_W-1:0] mainQ,
  output logic [DATA_W-1:0] shadowQ,
  output logic              mismatch
);
  logic [DATA_W-1:0] diffBits;

  // Main sample: either fresh input or the repaired late sample.
  always_ff @(posedge clkMain or negedge rstN) begin
    if (!rstN)               mainQ <= '0;
    else if (strb.takeShadow) mainQ <= shadowQ;
    else                     mainQ <= dIn;
  end

  // Late sample taken on the phase-delayed clock.
  always_ff @(posedge clkLate or negedge rstN) begin
    if (!rstN) shadowQ <= '0;
    else       shadowQ <= dIn;
  end

  // Bitwise difference, reduced to one flag.
  for (genvar b = 0; b < DATA_W; b++) begin : g_cmp
    assign diffBits[b] = mainQ[b] ^ shadowQ[b];
  end
  assign mismatch = |diffBits;
endmodule

// File: rtl/tsr_control.sv
module tsr_control
  import tsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clkMain,
  input  logic             rstN,
  input  logic             mismatch,
  output tsrStrobes_t      strb,
  output logic             stallQ,
  output logic [CNT_W-1:0] errCountQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic checkEn;
  logic hit;

  // The cycle after a repair carries next-slot data in the shadow: skip it.
  always_comb begin
    checkEn         = !stallQ;
    hit             = checkEn && mismatch;
    strb.takeShadow = hit;
    strb.raiseStall = hit;
  end

  always_ff @(posedge clkMain or negedge rstN) begin
    if (!rstN) stallQ <= 1'b0;
    else       stallQ <= strb.raiseStall;
  end

  always_ff @(posedge clkMain or negedge rstN) begin
    if (!rstN)                             errCountQ <= '0;
    else if (hit && errCountQ != CNT_MAX)  errCountQ <= errCountQ + 1'b1;
  end
endmodule

// File: rtl/timing_shadow_reg.sv
module timing_shadow_reg
  import tsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clkMain,
  input  logic              clkLate,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              stall,
  output logic [CNT_W-1:0]  errCount
);
  tsrStrobes_t       strb;
  logic [DATA_W-1:0] shadowQ;
  logic              mismatch;

  tsr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clkMain (clkMain),
    .clkLate (clkLate),
    .rstN    (rstN),
    .dIn     (dIn),
    .strb    (strb),
    .mainQ   (dOut),
    .shadowQ (shadowQ),
    .mismatch(mismatch)
  );

  tsr_control #(.CNT_W(CNT_W)) u_ctl (
    .clkMain  (clkMain),
    .rstN     (rstN),
    .mismatch (mismatch),
    .strb     (strb),
    .stallQ   (stall),
    .errCountQ(errCount)
  );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clkMain,
  input logic              rstN,
  input logic [DATA_W-1:0] dOut,
  input logic [DATA_W-1:0] shadowQ,
  input logic              stall,
  input logic [CNT_W-1:0]  errCount
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  AST_REPAIR_LOADS_SHADOW: assert property (@(posedge clkMain) disable iff (!rstN)
    (!stall && dOut != shadowQ) |=> (stall && dOut == $past(shadowQ))); // R3

  AST_STALL_SINGLE: assert property (@(posedge clkMain) disable iff (!rstN)
    stall |=> !stall); // R4

  AST_MATCH_NO_STALL: assert property (@(posedge clkMain) disable iff (!rstN)
    (!stall && dOut == shadowQ) |=> !stall); // R5

  AST_SKIP_AFTER_REPAIR: assert property (@(posedge clkMain) disable iff (!rstN)
    stall |=> $stable(errCount)); // R6

  AST_COUNT_STEP: assert property (@(posedge clkMain) disable iff (!rstN)
    !$stable(errCount) |-> (stall && errCount == $past(errCount) + 1'b1)); // R7

  AST_COUNT_HOLD_TOP: assert property (@(posedge clkMain) disable iff (!rstN)
    (errCount == CNT_TOP) |=> (errCount == CNT_TOP)); // R8
endmodule

bind timing_shadow_reg tsr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clkMain (clkMain),
  .rstN    (rstN),
  .dOut    (dOut),
  .shadowQ (shadowQ),
  .stall   (stall),
  .errCount(errCount)
);

// File: tb/sim_timing_shadow_reg.sv
`timescale 1ns/1ps
module sim_timing_shadow_reg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic              clkMain = 1'b0;
  logic              clkLate = 1'b0;
  logic              rstN    = 1'b0;
  logic [DATA_W-1:0] dIn     = '0;
  logic [DATA_W-1:0] dOut;
  logic              stall;
  logic [CNT_W-1:0]  errCount;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clkMain = ~clkMain;           // 125 MHz
  always @(clkMain) clkLate <= #2 clkMain; // late copy, 2 ns behind

  timing_shadow_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clkMain (clkMain),
    .clkLate (clkLate),
    .rstN    (rstN),
    .dIn     (dIn),
    .dOut    (dOut),
    .stall   (stall),
    .errCount(errCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Value set after the delayed edge: both samples agree.
  task automatic putClean(input logic [DATA_W-1:0] v);
    @(posedge clkMain); #4 dIn = v;
  endtask

  // Inject one error: main edge takes a, late edge takes b. Ends at stall cycle +5 ns.
  task automatic injectErr(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    putClean(a);
    @(posedge clkMain); #1 dIn = b;
    @(posedge clkMain); #5;
  endtask

  task automatic testReset();
    #1;
    check("R1 dOut in reset", dOut, 0);
    check("R1 stall in reset", stall, 0);
    check("R1 count in reset", errCount, 0);
    @(posedge clkMain); #4 rstN = 1'b1;
    @(posedge clkMain); #5;
    check("R1 stall after release", stall, 0);
    check("R1 count after release", errCount, 0);
  endtask

  task automatic testStream();
    logic [DATA_W-1:0] v;
    for (int i = 0; i < 6; i++) begin
      v = DATA_W'(16'h1111 * (i + 1));
      putClean(v);
      @(posedge clkMain); #5;
      check("R2 dOut follows dIn", dOut, v);
      check("R5 no stall on clean data", stall, 0);
    end
    check("R5 count unchanged", errCount, 0);
  endtask

  task automatic testRepair();
    int c0 = errCount;
    putClean(16'h00A5);
    @(posedge clkMain); #1 dIn = 16'h5A00;
    #4 check("R2 early sample visible", dOut, 16'h00A5);
    check("R3 no stall before compare", stall, 0);
    @(posedge clkMain); #5;
    check("R3 dOut repaired", dOut, 16'h5A00);
    check("R3 stall raised", stall, 1);
    check("R7 count step", errCount, c0 + 1);
    @(posedge clkMain); #5;
    check("R4 stall dropped", stall, 0);
    check("R4 dOut holds held input", dOut, 16'h5A00);
    check("R7 count steady", errCount, c0 + 1);
  endtask

  task automatic testSkip();
    int c0 = errCount;
    putClean(16'h0F0F);
    @(posedge clkMain); #1 dIn = 16'hF0F0;
    @(posedge clkMain); #1 dIn = 16'h3C3C;  // shadow changes inside the stall cycle
    #4 check("R3 repaired before skip", dOut, 16'hF0F0);
    @(posedge clkMain); #5;
    check("R6 no stall after repair", stall, 0);
    check("R4 fresh capture", dOut, 16'h3C3C);
    @(posedge clkMain); #5;
    check("R6 still no stall", stall, 0);
    check("R6 count single step", errCount, c0 + 1);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < CNT_TOP + 3; i++) begin
      injectErr(16'h0001, 16'h8000 | 16'(i));
      check("R8 stall still pulses", stall, 1);
      check("R8 repair still applied", dOut, 16'h8000 | i);
      @(posedge clkMain); #4;
    end
    check("R8 count saturated", errCount, CNT_TOP);
  endtask

  task automatic testReReset();
    @(posedge clkMain); #4 rstN = 1'b0;
    #2 check("R1 count cleared", errCount, 0);
    check("R1 dOut cleared", dOut, 0);
    @(posedge clkMain); #4 rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testStream();
    testRepair();
    testSkip();
    testSaturate();
    testReReset();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule